// File: doc/BRIEF.md
# Dual-Buffer Serial Frame Packer

This block gathers a stream of processed 8-bit samples into fixed frames of 105 bytes (840 bits) and sends each finished frame out on a single serial data line. Two payload stores take turns: while one collects incoming bytes, the other is read out bit by bit. Every frame opens and closes with a 32-bit synchronisation word. Between the opening word and the payload it carries a mode byte, a power-status byte and a 16-bit timestamp. The timestamp records the timer value at the first payload sample, so a receiver can place later frames in time even if one frame is lost.

The serial side is paced by an internal divider. One bit lasts `BIT_DIV` system clocks. With an 8 MHz system clock and the default divider the line runs at 1 Mbps, and one frame takes 0.84 ms. A companion clock output rises in the middle of each bit. A frame-active output stays high for exactly the 840 bit periods of a frame.

Top module: `dual_frame_packer`

## Requirements
- R1: While reset is held and on the first cycle after it, `ser_frame`, `ser_clk` and `ovf_flag` are low. After reset the first accepted byte goes into an empty store.
- R2: A frame is exactly 840 bits. `ser_frame` stays high for 840 × `BIT_DIV` cycles. `ser_clk` is low in the first half of each bit period and high in the second half, and it rises every `BIT_DIV` cycles. `ser_data` changes only at the start of a bit period, never while `ser_clk` is high, and `ser_clk` is low in the first cycle of a frame.
- R3: Bytes go out most-significant bit first, in this order: header 0xC3A55A3C (byte 0xC3 first), mode byte, power byte, timestamp high byte, timestamp low byte, 93 payload bytes in arrival order, and ender 0x3C5AA5C3 (byte 0x3C first).
- R4: In modes 0 (monitoring), 1 (compression) and 3, the timestamp field holds `timer_val` as sampled in the cycle where the frame's first payload byte is accepted.
- R5: In mode 2 (sensing), the timestamp field is sent as 0x0000 whatever `timer_val` holds.
- R6: The mode byte is {6'b0, `mode_sel`} sampled with the first payload byte. The power byte is `pwr_status` sampled with the 93rd (last) payload byte. Later changes to either input have no effect on that frame.
- R7: Once a store holds 93 bytes, filling moves to the other store while the full one is sent. Frames go out in the order they were completed. A frame that is already complete starts within 2 cycles after the previous frame ends.
- R8: A byte that arrives while the store due to fill is still waiting or sending is discarded, and `ovf_flag` rises. `ovf_flag` then stays high until reset.
- R9: Outside a frame, `ser_data` and `ser_clk` are low.
- R10: Discarded bytes never appear in any frame. After a store is freed, the next accepted byte becomes payload byte 0 of a new frame in that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Processed sample byte |
| in_valid | input | 1 | `in_byte` carries a sample this cycle |
| mode_sel | input | 2 | Operating mode: 0 monitoring, 1 compression, 2 sensing |
| pwr_status | input | 8 | Received-power status byte |
| timer_val | input | 16 | Free-running sample timer |
| ser_data | output | 1 | Serial frame data, MSB first |
| ser_clk | output | 1 | Bit clock; data is valid at its rising edge |
| ser_frame | output | 1 | High while a frame is being sent |
| ovf_flag | output | 1 | Sticky flag: a byte was discarded |

## Verification
The hardest condition to reach is the one where both stores are occupied: one is sending, the other is complete and waiting, and more bytes still arrive. The bench gets there by pushing two full frames back to back at one byte per clock. Both finish long before the first frame has left the line. It then pushes a few extra marker bytes, which must be dropped and must raise the flag. After the first store drains, a third frame is written. Its payload must hold only the new bytes, with none of the markers, and it must follow the second frame with no gap.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    localparam int FRAME_BYTES = 105;
    localparam int HEAD_BYTES  = 4;
    localparam int TAIL_BYTES  = 4;
    localparam int INFO_BYTES  = 4;
    localparam int BODY_BYTES  = FRAME_BYTES - HEAD_BYTES - TAIL_BYTES - INFO_BYTES;
    localparam int BODY_START  = HEAD_BYTES + INFO_BYTES;
    localparam int TAIL_START  = BODY_START + BODY_BYTES;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int BODY_W      = $clog2(BODY_BYTES);
    localparam int STAMP_W     = 16;

    localparam logic [31:0] SYNC_HEAD = 32'hC3A5_5A3C;
    localparam logic [31:0] SYNC_TAIL = 32'h3C5A_A5C3;

    typedef enum logic [1:0] {
        OP_MONITOR  = 2'd0,
        OP_COMPRESS = 2'd1,
        OP_SENSE    = 2'd2,
        OP_SPARE    = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic [7:0]         mode_b;
        logic [7:0]         pwr_b;
        logic [STAMP_W-1:0] stamp;
    } frame_info_t;

    // Byte idx of the outgoing frame, built from sync words, info and one payload byte.
    function automatic logic [7:0] pick_byte(input logic [IDX_W-1:0] idx,
                                             input frame_info_t info,
                                             input logic [7:0] body);
        int          i;
        logic [31:0] w;
        i = int'(idx);
        if (i < HEAD_BYTES) begin
            w = SYNC_HEAD >> (8 * (HEAD_BYTES - 1 - i));
            return w[7:0];
        end else if (i == HEAD_BYTES) begin
            return info.mode_b;
        end else if (i == HEAD_BYTES + 1) begin
            return info.pwr_b;
        end else if (i == HEAD_BYTES + 2) begin
            return info.stamp[15:8];
        end else if (i == HEAD_BYTES + 3) begin
            return info.stamp[7:0];
        end else if (i < TAIL_START) begin
            return body;
        end else begin
            w = SYNC_TAIL >> (8 * (FRAME_BYTES - 1 - i));
            return w[7:0];
        end
    endfunction

endpackage

// File: rtl/dfp_fill.sv
module dfp_fill
    import dfp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            in_byte_i,
    input  logic                  in_valid_i,
    input  logic [1:0]            mode_i,
    input  logic [7:0]            pwr_i,
    input  logic [STAMP_W-1:0]    stamp_i,
    input  logic                  rel_i,
    input  logic                  rel_sel_i,
    input  logic                  rd_sel_i,
    input  logic [BODY_W-1:0]     rd_idx_i,
    output logic [1:0]            ready_o,
    output logic                  ovf_o,
    output logic [7:0]            rd_byte_o,
    output frame_info_t           rd_info_o
);

    localparam logic [BODY_W-1:0] LAST_SLOT = BODY_W'(BODY_BYTES - 1);

    logic              wr_sel;
    logic [BODY_W-1:0] wr_cnt;
    logic [1:0]        rdy;
    logic              ovf;
    frame_info_t       info_q [2];
    logic [7:0]        bank_rd [2];
    logic              take;

    assign take = in_valid_i && !rdy[wr_sel];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_bank
            logic [7:0] mem [BODY_BYTES];
            always_ff @(posedge clk) begin
                if (take && (wr_sel == 1'(g)))
                    mem[wr_cnt] <= in_byte_i;
            end
            assign bank_rd[g] = mem[rd_idx_i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy    <= '0;
            wr_sel <= 1'b0;
            wr_cnt <= '0;
            ovf    <= 1'b0;
            for (int b = 0; b < 2; b++) info_q[b] <= '0;
        end else begin
            if (rel_i)
                rdy[rel_sel_i] <= 1'b0;
            if (in_valid_i && rdy[wr_sel])
                ovf <= 1'b1;
            if (take) begin
                if (wr_cnt == '0) begin
                    info_q[wr_sel].mode_b <= {6'b0, mode_i};
                    info_q[wr_sel].stamp  <= (mode_i == OP_SENSE) ? '0 : stamp_i;
                end
                if (wr_cnt == LAST_SLOT) begin
                    info_q[wr_sel].pwr_b <= pwr_i;
                    rdy[wr_sel]          <= 1'b1;
                    wr_sel               <= ~wr_sel;
                    wr_cnt               <= '0;
                end else begin
                    wr_cnt <= wr_cnt + 1'b1;
                end
            end
        end
    end

    assign ready_o   = rdy;
    assign ovf_o     = ovf;
    assign rd_byte_o = bank_rd[rd_sel_i];
    assign rd_info_o = info_q[rd_sel_i];

endmodule

// File: rtl/dfp_serial.sv
module dfp_serial
    import dfp_pkg::*;
#(
    parameter int BIT_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ready_i,
    input  logic [7:0]        rd_byte_i,
    input  frame_info_t       rd_info_i,
    output logic              rd_sel_o,
    output logic [BODY_W-1:0] rd_idx_o,
    output logic              rel_o,
    output logic              rel_sel_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_frame_o
);

    localparam int DIV_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(BIT_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF  = DIV_W'(BIT_DIV / 2);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);

    logic             active;
    logic             tx_sel;
    logic [IDX_W-1:0] byte_idx;
    logic [2:0]       bit_idx;
    logic [DIV_W-1:0] div_cnt;
    logic [7:0]       cur_byte;
    logic             tick;

    assign tick     = (div_cnt == DIV_LAST);
    assign rd_sel_o = tx_sel;
    assign rd_idx_o = BODY_W'(byte_idx - IDX_W'(BODY_START));
    assign cur_byte = pick_byte(byte_idx, rd_info_i, rd_byte_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            tx_sel    <= 1'b0;
            byte_idx  <= '0;
            bit_idx   <= 3'd7;
            div_cnt   <= '0;
            rel_o     <= 1'b0;
            rel_sel_o <= 1'b0;
        end else begin
            rel_o <= 1'b0;
            if (!active) begin
                if (ready_i[tx_sel]) begin
                    active   <= 1'b1;
                    byte_idx <= '0;
                    bit_idx  <= 3'd7;
                    div_cnt  <= '0;
                end
            end else if (tick) begin
                div_cnt <= '0;
                if (bit_idx != 3'd0) begin
                    bit_idx <= bit_idx - 3'd1;
                end else begin
                    bit_idx <= 3'd7;
                    if (byte_idx == LAST_BYTE) begin
                        active    <= 1'b0;
                        rel_o     <= 1'b1;
                        rel_sel_o <= tx_sel;
                        tx_sel    <= ~tx_sel;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign ser_data_o  = active && cur_byte[bit_idx];
    assign ser_clk_o   = active && (div_cnt >= DIV_HALF);
    assign ser_frame_o = active;

endmodule

// File: rtl/dual_frame_packer.sv
module dual_frame_packer
    import dfp_pkg::*;
#(
    parameter int BIT_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_byte,
    input  logic        in_valid,
    input  logic [1:0]  mode_sel,
    input  logic [7:0]  pwr_status,
    input  logic [15:0] timer_val,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        ser_frame,
    output logic        ovf_flag
);

    logic [1:0]        ready;
    logic              rd_sel;
    logic [BODY_W-1:0] rd_idx;
    logic [7:0]        rd_byte;
    frame_info_t       rd_info;
    logic              rel;
    logic              rel_sel;

    dfp_fill u_fill (
        .clk        (clk),
        .rst        (rst),
        .in_byte_i  (in_byte),
        .in_valid_i (in_valid),
        .mode_i     (mode_sel),
        .pwr_i      (pwr_status),
        .stamp_i    (timer_val),
        .rel_i      (rel),
        .rel_sel_i  (rel_sel),
        .rd_sel_i   (rd_sel),
        .rd_idx_i   (rd_idx),
        .ready_o    (ready),
        .ovf_o      (ovf_flag),
        .rd_byte_o  (rd_byte),
        .rd_info_o  (rd_info)
    );

    dfp_serial #(.BIT_DIV(BIT_DIV)) u_ser (
        .clk         (clk),
        .rst         (rst),
        .ready_i     (ready),
        .rd_byte_i   (rd_byte),
        .rd_info_i   (rd_info),
        .rd_sel_o    (rd_sel),
        .rd_idx_o    (rd_idx),
        .rel_o       (rel),
        .rel_sel_o   (rel_sel),
        .ser_data_o  (ser_data),
        .ser_clk_o   (ser_clk),
        .ser_frame_o (ser_frame)
    );

endmodule

// File: rtl/dfp_checker.sv
module dfp_checker (
    input logic clk,
    input logic rst,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_frame,
    input logic ovf_flag
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_frame && !ser_clk && !ovf_flag));

    assert_quiet_line_R9: assert property (@(posedge clk) disable iff (rst)
        !ser_frame |-> (!ser_data && !ser_clk));

    assert_stable_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    assert_frame_opens_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_frame) |-> !ser_clk);

    assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

endmodule

bind dual_frame_packer dfp_checker u_dfp_checker (
    .clk       (clk),
    .rst       (rst),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_frame (ser_frame),
    .ovf_flag  (ovf_flag)
);

// File: tb/dual_frame_packer_test.sv
module dual_frame_packer_test;

    localparam int DIV = 4;
    localparam int NFR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic [7:0]  pwr_status = '0;
    logic [15:0] timer_val = '0;
    logic        ser_data, ser_clk, ser_frame, ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_frame_packer #(.BIT_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .mode_sel(mode_sel), .pwr_status(pwr_status), .timer_val(timer_val),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_frame(ser_frame),
        .ovf_flag(ovf_flag)
    );

    // Line monitor: rebuilds frames from the serial pins
    logic [7:0] cap [NFR][105];
    int   fr_bits [NFR];
    int   fr_cyc  [NFR];
    int   fr_st   [NFR];
    int   fr_en   [NFR];
    int   nfr = 0, nbits = 0, hi_cyc = 0, cyc = 0, last_rise = 0, per_err = 0;
    logic [7:0] acc = '0;
    logic prev_sclk = 1'b0, prev_frame = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_sclk  = 1'b0;
            prev_frame = 1'b0;
        end else begin
            if (ser_frame && !prev_frame && nfr < NFR) begin
                fr_st[nfr] = cyc;
                nbits = 0;
                hi_cyc = 0;
            end
            if (ser_frame) hi_cyc++;
            if (ser_clk && !prev_sclk) begin
                if (nbits > 0 && (cyc - last_rise) != DIV) per_err++;
                last_rise = cyc;
                acc = {acc[6:0], ser_data};
                nbits++;
                if (nbits % 8 == 0 && nbits <= 840 && nfr < NFR)
                    cap[nfr][nbits/8 - 1] = acc;
            end
            if (!ser_frame && prev_frame && nfr < NFR) begin
                fr_bits[nfr] = nbits;
                fr_cyc[nfr]  = hi_cyc;
                fr_en[nfr]   = cyc;
                nfr++;
            end
            prev_sclk  = ser_clk;
            prev_frame = ser_frame;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_frame(input logic [1:0] m, input logic [7:0] pw,
                              input logic [15:0] ts, input logic [7:0] base,
                              input logic [7:0] step);
        for (int k = 0; k < 93; k++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_byte    = 8'(base + k * step);
            mode_sel   = (k == 0) ? m : (m ^ 2'b01);
            timer_val  = (k == 0) ? ts : 16'(ts + k + 7);
            pwr_status = (k == 92) ? pw : ~pw;
        end
        @(negedge clk);
        in_valid = 1'b0;
        mode_sel = m ^ 2'b01;
        pwr_status = ~pw;
    endtask

    task automatic wait_frames(input int n);
        int lim = 0;
        while (nfr < n && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        if (nfr < n) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d frames expected %0d", nfr, n);
        end
    endtask

    task automatic check_frame(input int f, input logic [1:0] m, input logic [7:0] pw,
                               input logic [15:0] ts, input logic [7:0] base,
                               input logic [7:0] step, input string ts_tag,
                               input string body_tag);
        logic [31:0] hd = 32'hC3A55A3C;
        logic [31:0] en = 32'h3C5AA5C3;
        chk("R2 bit count", fr_bits[f], 840);
        chk("R2 frame cycles", fr_cyc[f], 840 * DIV);
        for (int i = 0; i < 4; i++) begin
            chk("R3 header", cap[f][i], hd[31 - 8*i -: 8]);
            chk("R3 ender", cap[f][101 + i], en[31 - 8*i -: 8]);
        end
        chk("R6 mode byte", cap[f][4], {6'b0, m});
        chk("R6 power byte", cap[f][5], pw);
        chk(ts_tag, {cap[f][6], cap[f][7]}, ts);
        for (int k = 0; k < 93; k++)
            chk(body_tag, cap[f][8 + k], 8'(base + k * step));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ser_frame", ser_frame, 0);
        chk("R1 ser_clk", ser_clk, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R9 ser_data idle", ser_data, 0);
    endtask

    task automatic t_monitor;
        push_frame(2'd0, 8'h77, 16'h1234, 8'h10, 8'd3);
        wait_frames(1);
        check_frame(0, 2'd0, 8'h77, 16'h1234, 8'h10, 8'd3, "R4 stamp", "R3 payload");
        chk("R2 bit period", per_err, 0);
        chk("R8 no overflow", ovf_flag, 0);
    endtask

    task automatic t_sense;
        push_frame(2'd2, 8'h3C, 16'hBEEF, 8'hF0, 8'd1);
        wait_frames(2);
        check_frame(1, 2'd2, 8'h3C, 16'h0000, 8'hF0, 8'd1, "R5 zero stamp", "R3 payload");
        @(negedge clk);
        chk("R9 ser_clk idle", ser_clk, 0);
        chk("R9 ser_data idle", ser_data, 0);
    endtask

    task automatic t_pingpong_overflow;
        push_frame(2'd1, 8'h11, 16'h0A0B, 8'h00, 8'd5);
        push_frame(2'd1, 8'h22, 16'h7777, 8'h80, 8'd7);
        chk("R8 no overflow yet", ovf_flag, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = 8'hEE;
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 overflow set", ovf_flag, 1);
        wait_frames(3);
        push_frame(2'd0, 8'h55, 16'h4321, 8'h40, 8'd9);
        wait_frames(5);
        check_frame(2, 2'd1, 8'h11, 16'h0A0B, 8'h00, 8'd5, "R4 stamp", "R7 first frame");
        check_frame(3, 2'd1, 8'h22, 16'h7777, 8'h80, 8'd7, "R4 stamp", "R7 second frame");
        chk("R7 gap small", (fr_st[3] - fr_en[2]) <= 2, 1);
        chk("R7 gap small", (fr_st[4] - fr_en[3]) <= 2, 1);
        check_frame(4, 2'd0, 8'h55, 16'h4321, 8'h40, 8'd9, "R4 stamp", "R10 refill payload");
        chk("R8 overflow sticky", ovf_flag, 1);
        chk("R2 bit period", per_err, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 frame in reset", ser_frame, 0);
        rst = 1'b0;
        t_reset();
        t_monitor();
        t_sense();
        t_pingpong_overflow();
        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule